// File: doc/BRIEF.md
# Interrupt Aggregator with Routing

This block gathers sixteen interrupt sources and drives two interrupt lines, one for a host and one for the local core. It belongs to a small embedded controller. Each source has a pending bit. Software sets or clears pending bits through two write-only registers: a 1 in a written bit sets that bit, or clears it, and a 0 leaves it unchanged. A separate register reads back the pending state. Each source has its own capture mode, chosen by one bit. In edge mode a rising input latches the pending bit until software clears it. In level mode the reported pending bit follows the input while the input is high.

The mask has its own pair of write-one registers and a read-back register. A 32-bit destination register holds an enable bit and a target bit for each source. A source drives an output line only when it is pending, unmasked and enabled. Each output is the OR of the sources routed to it.

Source bit i is the same bit position in every register. Bits 0 to 7 are, in order: general timer, watchdog, method, context switch, halt, external error, software event 0 and software event 1. Bits 8 to 15 are external sources. All sources enter on the block clock.

Top module: `irq_router`

## Requirements
- R1: After reset, pending, mask, mode and destination all read zero, and both interrupt outputs are low.
- R2: In edge mode (mode bit 0), a 0-to-1 change on a source input sets its pending bit one clock later. The bit stays set after the input falls. A rising edge in the same cycle as a clear of that bit still leaves the bit set.
- R3: A write to offset 0x04 clears every pending bit written as 1. In level mode, a clear has no lasting effect while the source input is high.
- R4: A write to offset 0x00 sets every pending bit written as 1, whatever the source input is.
- R5: Offset 0x08 reads the pending state in bits 0 to 15. Writes to 0x08 have no effect. The write-only aliases at 0x00, 0x04, 0x10 and 0x14 read as zero.
- R6: Writes to offset 0x10 set mask bits written as 1, and writes to 0x14 clear them. Offset 0x18 reads the whole mask. A mask bit of 1 lets its source through.
- R7: The mode register at 0x0C is read/write. A bit value of 1 selects level mode, and the pending bit then reads 1 in the same cycle that the input is high.
- R8: The destination register at 0x1C is read/write. Bits 0 to 15 enable each source. Bits 16 to 31 select each source's target: 1 selects host_irq_o and 0 selects core_irq_o.
- R9: host_irq_o is the OR, over all sources, of pending AND mask AND enable AND target. core_irq_o is the same OR with the target bit inverted.
- R10: Written bits 16 to 31 are ignored for the 16-bit registers and read back as zero. Accesses with addr_i[1:0] not equal to zero are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 5 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_i | input | 16 | Interrupt source inputs, synchronous to clk_i |
| host_irq_o | output | 1 | Interrupt line to the host |
| core_irq_o | output | 1 | Interrupt line to the local core |

## Verification
Directed sequences drive pulses and held-high inputs in each mode. These show the difference between the sticky edge capture and the level capture that follows the input. They also cover the two hard cases: a clear in the same cycle as a rising edge, and a clear while a level source is high. Routing is checked by moving one pending source between targets, disabling it and masking it. This shows each of the four gating terms acting on its own. A long random phase writes to every offset, aligned and misaligned, with random data while the sources toggle at random. After every cycle the bench compares both outputs and the pending read-back against a reference model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned NUM_SRC = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned WIDX_W  = ADDR_W - 2;

  // word index = byte offset >> 2
  localparam logic [WIDX_W-1:0] W_PSET  = 3'd0;
  localparam logic [WIDX_W-1:0] W_PCLR  = 3'd1;
  localparam logic [WIDX_W-1:0] W_PSTAT = 3'd2;
  localparam logic [WIDX_W-1:0] W_MODE  = 3'd3;
  localparam logic [WIDX_W-1:0] W_MSET  = 3'd4;
  localparam logic [WIDX_W-1:0] W_MCLR  = 3'd5;
  localparam logic [WIDX_W-1:0] W_MASK  = 3'd6;
  localparam logic [WIDX_W-1:0] W_DEST  = 3'd7;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise;
    assign rise = src_i[i] & ~src_q[i] & ~mode_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        src_q[i]  <= src_i[i];
        pend_q[i] <= set_i[i] | rise | (pend_q[i] & ~clr_i[i]);
      end
    end

    // level sources report their live input on top of the stored bit
    assign pend_o[i] = pend_q[i] | (mode_i[i] & src_i[i]);

    AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[i] && src_i[i] && !src_q[i]) |=> pend_q[i]); // R2
    AST_SET_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]); // R4
    AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i] && (mode_i[i] || !src_i[i] || src_q[i])) |=> !pend_q[i]); // R3
    AST_LEVEL_SHOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] && src_i[i]) |-> pend_o[i]); // R7
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              acc_ok_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      pset_o,
  output logic [N-1:0]      pclr_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      den_o,
  output logic [N-1:0]      tsel_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic         wr;
  logic [N-1:0] wlo, whi;
  logic [N-1:0] mode_q, mask_q, den_q, tsel_q;

  assign wr  = wr_en_i & acc_ok_i;
  assign wlo = wdata_i[N-1:0];
  assign whi = wdata_i[2*N-1:N];

  assign pset_o = (wr && widx_i == W_PSET) ? wlo : '0;
  assign pclr_o = (wr && widx_i == W_PCLR) ? wlo : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '0;
      den_q  <= '0;
      tsel_q <= '0;
    end else if (wr) begin
      case (widx_i)
        W_MODE: mode_q <= wlo;
        W_MSET: mask_q <= mask_q | wlo;
        W_MCLR: mask_q <= mask_q & ~wlo;
        W_DEST: begin
          den_q  <= wlo;
          tsel_q <= whi;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_ok_i) begin
      case (widx_i)
        W_PSTAT: rdata_o = {{PAD_W{1'b0}}, pend_i};
        W_MODE:  rdata_o = {{PAD_W{1'b0}}, mode_q};
        W_MASK:  rdata_o = {{PAD_W{1'b0}}, mask_q};
        W_DEST:  rdata_o = {tsel_q, den_q};
        default: rdata_o = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign den_o  = den_q;
  assign tsel_o = tsel_q;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx_i == W_MSET) |=> ((mask_q & $past(wlo)) == $past(wlo))); // R6
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx_i == W_MCLR) |=> ((mask_q & $past(wlo)) == '0)); // R6
  AST_DEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && widx_i == W_DEST) |=> ($stable(den_q) && $stable(tsel_q))); // R8
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && widx_i == W_MODE) |=> $stable(mode_q)); // R7
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] den_i,
  input  logic [N-1:0] tsel_i,
  output logic         host_o,
  output logic         core_o
);
  logic [N-1:0] live;
  logic [N-1:0] to_host, to_core;

  assign live = pend_i & mask_i & den_i;

  for (genvar i = 0; i < N; i++) begin : g_steer
    assign to_host[i] = live[i] &  tsel_i[i];
    assign to_core[i] = live[i] & ~tsel_i[i];
  end

  assign host_o = |to_host;
  assign core_o = |to_core;

  AST_QUIET_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_i == '0) || (den_i == '0) || (pend_i == '0)) |-> (!host_o && !core_o)); // R9
  AST_HOST_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_i == '0) |-> !host_o); // R8
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              host_irq_o,
  output logic              core_irq_o
);
  logic [NUM_SRC-1:0] pset, pclr, mode, mask, den, tsel, pend;
  logic               acc_ok;

  assign acc_ok = (addr_i[1:0] == 2'b00);

  irq_regs #(.N(NUM_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .acc_ok_i (acc_ok),
    .widx_i   (addr_i[ADDR_W-1:2]),
    .wdata_i  (wdata_i),
    .pend_i   (pend),
    .pset_o   (pset),
    .pclr_o   (pclr),
    .mode_o   (mode),
    .mask_o   (mask),
    .den_o    (den),
    .tsel_o   (tsel),
    .rdata_o  (rdata_o)
  );

  irq_capture #(.N(NUM_SRC)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .mode_i (mode),
    .set_i  (pset),
    .clr_i  (pclr),
    .pend_o (pend)
  );

  irq_route #(.N(NUM_SRC)) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .mask_i (mask),
    .den_i  (den),
    .tsel_i (tsel),
    .host_o (host_irq_o),
    .core_o (core_irq_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!host_irq_o && !core_irq_o)); // R1
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] src = '0;
  logic        host_irq, core_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_pend = '0, m_prev = '0, m_mode = '0, m_mask = '0;
  logic [31:0] m_dest = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src),
    .host_irq_o(host_irq), .core_irq_o(core_irq)
  );

  function automatic logic [15:0] eff_pend();
    return m_pend | (m_mode & src);
  endfunction

  function automatic logic exp_out(input logic host);
    logic [15:0] live;
    live = eff_pend() & m_mask & m_dest[15:0];
    return host ? |(live & m_dest[31:16]) : |(live & ~m_dest[31:16]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd2: return {16'h0, eff_pend()};
      3'd3: return {16'h0, m_mode};
      3'd6: return {16'h0, m_mask};
      3'd7: return m_dest;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic [4:0] a, input logic [31:0] d);
    logic [15:0] setv, clrv, rise;
    setv = '0; clrv = '0;
    rise = src & ~m_prev & ~m_mode;
    if (w && a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: setv = d[15:0];
        3'd1: clrv = d[15:0];
        3'd3: m_mode = d[15:0];
        3'd4: m_mask = m_mask | d[15:0];
        3'd5: m_mask = m_mask & ~d[15:0];
        3'd7: m_dest = d;
        default: ;
      endcase
    end
    m_pend = setv | rise | (m_pend & ~clrv);
    m_prev = src;
  endtask

  // one clock: drive, edge, update model, then settle
  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d, input logic [15:0] s);
    wr_en = w; addr = a; wdata = d; src = s;
    @(posedge clk);
    model_edge(w, a, d);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    addr = a; wr_en = 1'b0;
    #1;
    chk(rdata == exp_rd(a), tag, rdata, exp_rd(a));
  endtask

  task automatic outs(input string tag);
    chk(host_irq == exp_out(1'b1), {tag, " host"}, {31'h0, host_irq}, {31'h0, exp_out(1'b1)});
    chk(core_irq == exp_out(1'b0), {tag, " core"}, {31'h0, core_irq}, {31'h0, exp_out(1'b0)});
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_P * 2 + 3);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(5'h08, "R1 pending"); rd(5'h18, "R1 mask"); rd(5'h0C, "R1 mode");
    rd(5'h1C, "R1 dest"); outs("R1");

    // R6 mask set/readback, R10 upper bits ignored
    cyc(1, 5'h10, 32'hFFFF_00F0, src);
    rd(5'h18, "R6 mask set"); rd(5'h10, "R5 alias reads zero");
    cyc(1, 5'h14, 32'h0000_0030, src);
    rd(5'h18, "R6 mask clear");
    cyc(1, 5'h10, 32'hFFFF_FFFF, src);
    rd(5'h18, "R10 mask upper zero");
    cyc(1, 5'h1C, 32'h0000_FFFF, src);
    rd(5'h1C, "R8 dest readback");

    // R2 edge capture, sticky
    cyc(0, 5'h00, 0, 16'h0008);
    outs("R2 rise"); rd(5'h08, "R2 pending latched");
    cyc(0, 5'h00, 0, 16'h0000);
    rd(5'h08, "R2 sticky after fall"); outs("R2 sticky");
    cyc(1, 5'h04, 32'h0000_0008, 16'h0000);
    rd(5'h08, "R3 clear"); outs("R3 cleared");
    // R2 rise concurrent with clear keeps bit
    cyc(1, 5'h04, 32'h0000_0008, 16'h0008);
    rd(5'h08, "R2 rise beats clear");
    cyc(1, 5'h04, 32'h0000_FFFF, 16'h0000);

    // R4 set alias
    cyc(1, 5'h00, 32'hFFFF_0200, 16'h0000);
    rd(5'h08, "R4 set forces"); outs("R4");

    // R5 writes to status ignored
    cyc(1, 5'h08, 32'h0000_FFFF, 16'h0000);
    rd(5'h08, "R5 status write ignored");
    cyc(1, 5'h04, 32'h0000_0200, 16'h0000);

    // R7 level mode
    cyc(1, 5'h0C, 32'hFFFF_0020, 16'h0000);
    rd(5'h0C, "R7 mode readback");
    src = 16'h0020; #1;
    rd(5'h08, "R7 level same cycle"); outs("R7 level");
    cyc(1, 5'h04, 32'h0000_0020, 16'h0020);
    rd(5'h08, "R3 clear no effect while high");
    cyc(0, 5'h00, 0, 16'h0000);
    rd(5'h08, "R7 level follows low"); outs("R7 low");

    // R8 routing to host, enable gating; R9 mask gating
    cyc(1, 5'h00, 32'h0000_0002, 16'h0000);
    outs("R8 to core");
    cyc(1, 5'h1C, 32'h0002_FFFF, 16'h0000);
    outs("R8 to host");
    cyc(1, 5'h1C, 32'h0002_FFFD, 16'h0000);
    outs("R8 disabled");
    cyc(1, 5'h1C, 32'h0002_FFFF, 16'h0000);
    cyc(1, 5'h14, 32'h0000_0002, 16'h0000);
    outs("R9 masked");

    // R10 misaligned access ignored
    cyc(1, 5'h11, 32'h0000_FFFF, 16'h0000);
    rd(5'h18, "R10 misaligned write"); rd(5'h1A, "R10 misaligned read");

    // random phase: R9 and register behaviour against model
    for (int k = 0; k < 600; k++) begin
      logic [4:0]  a;
      logic [31:0] d;
      logic [15:0] s;
      a = ($urandom % 8 == 0) ? 5'($urandom) : {3'($urandom), 2'b00};
      d = $urandom;
      s = ($urandom % 4 == 0) ? 16'($urandom) : src;
      cyc(1'($urandom), a, d, s);
      outs("R9 random");
      rd(5'h08, "R5 random pending");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule